// File: doc/BRIEF.md
# Tile Background Scanline Renderer

This block produces the background layer of a 256x192 tile-based display, one scanline at a time. A pulse on `line_start` together with a line number starts a fetch phase. During this phase the block reads 33 name-map entries and their 4-bit-per-pixel tile rows from a 16-bit-wide video memory through a single synchronous read port. It applies the scroll offsets and the flip attributes, and fills an internal 256-entry line buffer with a colour index, a palette bit and a priority bit for every screen pixel.

When `busy` drops, the line can be read out. A pixel request names an x position, and one cycle later the block returns the final 6-bit colour from its internal colour RAM. It also returns a priority flag and a transparency flag, so a later stage can merge the background with sprites. A small register port sets the scroll values, the left-column mask, the backdrop entry and the colour RAM contents.

Top module: `bg_scanline_renderer`

## Requirements
- R1: After reset `busy`, `mem_rd_en` and `pix_valid` are low. Both scroll values, the control register, the colour RAM index and all 32 colour RAM entries are zero.
- R2: A `line_start` pulse while idle raises `busy` in the next cycle, and `mem_rd_en` is high in that same cycle. `busy` then stays high for exactly 132 cycles (33 tiles of 4 cycles each). `mem_rdata` is taken one cycle after the read it answers. `mem_rd_en` is never high while `busy` is low.
- R3: A request with `pix_req` high and `pix_x` = x gives `pix_valid` high in the next cycle, and low in cycles that follow no request. The pixel shown is map pixel column (x + sx) mod 256 and map pixel row (line + sy) mod 224. The values sx and sy are the scroll register values captured at `line_start`; later scroll writes do not affect the current line.
- R4: A map entry is a 16-bit word at word address MAP_BASE + row*32 + column. Bits [8:0] hold the tile index, bit 9 horizontal flip, bit 10 vertical flip, bit 11 palette select and bit 12 priority.
- R5: Tile t, row r lives in two words at TILE_BASE + t*16 + r*2. The first word holds plane 0 in [7:0] and plane 1 in [15:8]; the second holds plane 2 in [7:0] and plane 3 in [15:8]. Colour index bit n comes from plane n, and the leftmost pixel uses bit 7 of each plane.
- R6: Vertical flip reads tile row 7-r in place of r. Horizontal flip takes the leftmost pixel from bit 0 of each plane.
- R7: Map rows wrap within 28 rows (224 pixel rows), and map columns wrap within 32 columns.
- R8: Register 3 sets the 5-bit colour RAM index; bit 4 selects the palette and bits [3:0] the entry. Each write to register 4 stores data bits [5:0] (red [1:0], green [3:2], blue [5:4]) at that index, then increments the index, wrapping from 31 to 0.
- R9: A pixel with colour index 0 reports `pix_transp` high and `pix_prio` low. It still carries the colour RAM entry of its palette.
- R10: A pixel with a nonzero colour index reports `pix_transp` low, and `pix_prio` equal to the priority bit of its map entry.
- R11: When control bit 0 is set, pixels with x below 8 output colour RAM entry 16 + control bits [7:4], with `pix_transp` low and `pix_prio` high.
- R12: Map entry bits [15:13] have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 scroll x, 1 scroll y, 2 control, 3 colour index, 4 colour data |
| reg_wdata | input | 8 | Register write data |
| line_start | input | 1 | Starts the fetch for one scanline |
| line_num | input | 8 | Visible line number (0..191), sampled with `line_start` |
| busy | output | 1 | Fetch phase in progress |
| mem_rd_en | output | 1 | Video memory read request |
| mem_addr | output | AW (13) | Video memory word address |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| pix_req | input | 1 | Pixel read request |
| pix_x | input | 8 | Screen x of the requested pixel |
| pix_valid | output | 1 | Pixel outputs valid |
| pix_rgb | output | CW (6) | Final colour |
| pix_prio | output | 1 | Background drawn over sprites |
| pix_transp | output | 1 | Background pixel is transparent |

## Verification
A wrong fetch address, plane order or flip decision corrupts individual pixel colours. Each pixel is compared with a behavioural model in the cycle after its request, so a fault shows within one line readout, at the first affected x. A fault in the fetch sequencing changes the length of the `busy` window, which is measured on the line where it occurs. A stuck or mis-stepping colour RAM index leaves wrong colours on every later pixel that uses the affected entries. Wrong mask or transparency handling shows in the flag outputs on the same cycle as the colour.

// File: rtl/bg_pkg.sv
package bg_pkg;
   localparam int TILE_PIX = 8;
   localparam int LINE_W   = 256;
   localparam int XW       = $clog2(LINE_W);
   localparam int MAP_COLS = LINE_W / TILE_PIX;

   localparam logic [2:0] RA_SCX  = 3'd0;
   localparam logic [2:0] RA_SCY  = 3'd1;
   localparam logic [2:0] RA_CTRL = 3'd2;
   localparam logic [2:0] RA_CIDX = 3'd3;
   localparam logic [2:0] RA_CDAT = 3'd4;

   typedef struct packed {
      logic [2:0] spare;
      logic       prio;
      logic       pal;
      logic       vflip;
      logic       hflip;
      logic [8:0] tile;
   } map_ent_t;

   typedef struct packed {
      logic       prio;
      logic       pal;
      logic [3:0] ci;
   } lb_ent_t;
endpackage

// File: rtl/bg_regfile.sv
module bg_regfile
   import bg_pkg::*;
#(
   parameter int CW   = 6,
   parameter int NPAL = 2,
   localparam int NENT = NPAL * 16,
   localparam int IW   = $clog2(NENT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    scroll_x,
   output logic [7:0]    scroll_y,
   output logic          mask_en,
   input  logic [IW-1:0] rd_idx,
   output logic [CW-1:0] rd_rgb,
   output logic [CW-1:0] bd_rgb
);
   logic [CW-1:0] cram [NENT];
   logic [IW-1:0] cidx;
   logic [7:0]    ctrl;
   logic [IW-1:0] bd_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NENT; i++) cram[i] <= '0;
         cidx     <= '0;
         ctrl     <= '0;
         scroll_x <= '0;
         scroll_y <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            RA_SCX:  scroll_x <= reg_wdata;
            RA_SCY:  scroll_y <= reg_wdata;
            RA_CTRL: ctrl     <= reg_wdata;
            RA_CIDX: cidx     <= reg_wdata[IW-1:0];
            RA_CDAT: begin
               cram[cidx] <= reg_wdata[CW-1:0];
               cidx       <= cidx + 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign mask_en = ctrl[0];
   assign bd_idx  = IW'(16) + IW'(ctrl[7:4]);
   assign rd_rgb  = cram[rd_idx];
   assign bd_rgb  = cram[bd_idx];

   p_cidx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_CDAT) |=> (cidx == $past(cidx) + 1'b1));

   p_cram_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_CDAT) |=> (cram[$past(cidx)] == $past(reg_wdata[CW-1:0])));
endmodule

// File: rtl/bg_fetch.sv
module bg_fetch
   import bg_pkg::*;
#(
   parameter int AW        = 13,
   parameter int MAP_BASE  = 'h1C00,
   parameter int TILE_BASE = 0,
   parameter int MAP_ROWS  = 28
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         line_start,
   input  logic [7:0]                   line_num,
   input  logic [7:0]                   scroll_x,
   input  logic [7:0]                   scroll_y,
   output logic                         busy,
   output logic                         mem_rd_en,
   output logic [AW-1:0]                mem_addr,
   input  logic [15:0]                  mem_rdata,
   output logic                         wr_en,
   output logic signed [10:0]           wr_x0,
   output lb_ent_t [TILE_PIX-1:0]       wr_ent
);
   localparam int SLOTS     = MAP_COLS + 1;
   localparam int MAP_PIX_H = MAP_ROWS * TILE_PIX;
   localparam int WPT       = TILE_PIX * TILE_PIX * 4 / 16;
   localparam int WPR       = WPT / TILE_PIX;
   localparam int FETCH_CYC = SLOTS * 4;
   localparam int SW        = $clog2(SLOTS);
   localparam int RW        = $clog2(MAP_ROWS);
   localparam int CLW       = $clog2(MAP_COLS);

   typedef enum logic [2:0] {F_IDLE, F_MAP, F_P01, F_P23, F_PUT} fst_t;

   fst_t           st;
   logic [2:0]     fine, trow, trow_now, trow_reg;
   logic [CLW-1:0] col;
   logic [RW-1:0]  row;
   logic [SW-1:0]  slot;
   map_ent_t       ent, ent_now;
   logic [15:0]    p01;
   logic [9:0]     vy_sum, vy;

   assign ent_now  = map_ent_t'(mem_rdata);
   assign trow_now = ent_now.vflip ? ~trow : trow;
   assign trow_reg = ent.vflip ? ~trow : trow;

   always_comb begin
      vy_sum = {2'b00, line_num} + {2'b00, scroll_y};
      if (vy_sum >= 10'(2 * MAP_PIX_H))  vy = vy_sum - 10'(2 * MAP_PIX_H);
      else if (vy_sum >= 10'(MAP_PIX_H)) vy = vy_sum - 10'(MAP_PIX_H);
      else                               vy = vy_sum;
   end

   always_comb begin
      mem_rd_en = 1'b0;
      mem_addr  = '0;
      case (st)
         F_MAP: begin
            mem_rd_en = 1'b1;
            mem_addr  = AW'(MAP_BASE) + AW'(row) * AW'(MAP_COLS) + AW'(col);
         end
         F_P01: begin
            mem_rd_en = 1'b1;
            mem_addr  = AW'(TILE_BASE) + AW'(ent_now.tile) * AW'(WPT) + AW'(trow_now) * AW'(WPR);
         end
         F_P23: begin
            mem_rd_en = 1'b1;
            mem_addr  = AW'(TILE_BASE) + AW'(ent.tile) * AW'(WPT) + AW'(trow_reg) * AW'(WPR) + AW'(1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= F_IDLE;
         fine <= '0;
         trow <= '0;
         col  <= '0;
         row  <= '0;
         slot <= '0;
         ent  <= '0;
         p01  <= '0;
      end else begin
         case (st)
            F_IDLE: if (line_start) begin
               fine <= scroll_x[2:0];
               col  <= CLW'(scroll_x >> 3);
               row  <= RW'(vy >> 3);
               trow <= vy[2:0];
               slot <= '0;
               st   <= F_MAP;
            end
            F_MAP: st <= F_P01;
            F_P01: begin
               ent <= ent_now;
               st  <= F_P23;
            end
            F_P23: begin
               p01 <= mem_rdata;
               st  <= F_PUT;
            end
            F_PUT: begin
               col  <= col + 1'b1;
               slot <= slot + 1'b1;
               st   <= (slot == SW'(SLOTS - 1)) ? F_IDLE : F_MAP;
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   assign busy  = (st != F_IDLE);
   assign wr_en = (st == F_PUT);
   assign wr_x0 = $signed(11'(slot) << 3) - $signed(11'(fine));

   for (genvar p = 0; p < TILE_PIX; p++) begin : g_lane
      logic [2:0] bsel;
      assign bsel = ent.hflip ? 3'(p) : 3'(TILE_PIX - 1 - p);
      assign wr_ent[p] = '{prio: ent.prio, pal: ent.pal,
                           ci: {mem_rdata[8 + bsel], mem_rdata[bsel], p01[8 + bsel], p01[bsel]}};
   end

   logic [7:0] busy_cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cyc <= '0;
      else if (busy) busy_cyc <= busy_cyc + 1'b1;
      else           busy_cyc <= '0;
   end

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !busy) |=> (busy && mem_rd_en));

   p_fetch_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_cyc == 8'(FETCH_CYC)));

   p_line_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !busy) |-> (line_num < 8'd192));
endmodule

// File: rtl/bg_lineout.sv
module bg_lineout
   import bg_pkg::*;
#(
   parameter int CW = 6,
   parameter int IW = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic signed [10:0]     wr_x0,
   input  lb_ent_t [TILE_PIX-1:0] wr_ent,
   input  logic                   pix_req,
   input  logic [XW-1:0]          pix_x,
   input  logic                   mask_en,
   output logic [IW-1:0]          rd_idx,
   input  logic [CW-1:0]          rd_rgb,
   input  logic [CW-1:0]          bd_rgb,
   output logic                   pix_valid,
   output logic [CW-1:0]          pix_rgb,
   output logic                   pix_prio,
   output logic                   pix_transp
);
   lb_ent_t                      lbuf [LINE_W];
   logic [TILE_PIX-1:0]          wok;
   logic [TILE_PIX-1:0][XW-1:0]  wxa;

   for (genvar p = 0; p < TILE_PIX; p++) begin : g_wpos
      logic signed [10:0] wx;
      assign wx     = wr_x0 + $signed(11'(p));
      assign wok[p] = !wx[10] && (wx < $signed(11'(LINE_W)));
      assign wxa[p] = wx[XW-1:0];
   end

   always_ff @(posedge clk) begin
      for (int p = 0; p < TILE_PIX; p++) begin
         if (wr_en && wok[p]) lbuf[wxa[p]] <= wr_ent[p];
      end
   end

   lb_ent_t cur;
   logic    masked;
   assign cur    = lbuf[pix_x];
   assign rd_idx = IW'({cur.pal, cur.ci});
   assign masked = mask_en && (pix_x < XW'(TILE_PIX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_valid  <= 1'b0;
         pix_rgb    <= '0;
         pix_prio   <= 1'b0;
         pix_transp <= 1'b0;
      end else begin
         pix_valid <= pix_req;
         if (pix_req) begin
            if (masked) begin
               pix_rgb    <= bd_rgb;
               pix_prio   <= 1'b1;
               pix_transp <= 1'b0;
            end else begin
               pix_rgb    <= rd_rgb;
               pix_transp <= (cur.ci == 4'd0);
               pix_prio   <= cur.prio && (cur.ci != 4'd0);
            end
         end
      end
   end

   p_transp_noprio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_transp) |-> !pix_prio);

   p_mask_col_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && mask_en && pix_x < XW'(TILE_PIX)) |=>
      (pix_valid && !pix_transp && pix_prio && pix_rgb == $past(bd_rgb)));
endmodule

// File: rtl/bg_scanline_renderer.sv
module bg_scanline_renderer
   import bg_pkg::*;
#(
   parameter int AW        = 13,
   parameter int MAP_BASE  = 'h1C00,
   parameter int TILE_BASE = 0,
   parameter int MAP_ROWS  = 28,
   parameter int CW        = 6,
   parameter int NPAL      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [7:0]    reg_wdata,
   input  logic          line_start,
   input  logic [7:0]    line_num,
   output logic          busy,
   output logic          mem_rd_en,
   output logic [AW-1:0] mem_addr,
   input  logic [15:0]   mem_rdata,
   input  logic          pix_req,
   input  logic [7:0]    pix_x,
   output logic          pix_valid,
   output logic [CW-1:0] pix_rgb,
   output logic          pix_prio,
   output logic          pix_transp
);
   localparam int NENT = NPAL * 16;
   localparam int IW   = $clog2(NENT);

   initial begin : elab_chk
      assert (MAP_ROWS * TILE_PIX >= 192 && MAP_ROWS * TILE_PIX <= 256)
         else $error("map height must cover the visible lines");
      assert (MAP_BASE + MAP_COLS * MAP_ROWS <= 2 ** AW)
         else $error("name map does not fit the address space");
      assert (TILE_BASE + 512 * 16 <= 2 ** AW)
         else $error("tile area does not fit the address space");
      assert (NPAL >= 2 && (NPAL & (NPAL - 1)) == 0)
         else $error("palette count must be a power of two, at least two");
      assert (CW % 3 == 0)
         else $error("colour width must split evenly into three channels");
   end

   logic [7:0]             scroll_x, scroll_y;
   logic                   mask_en;
   logic [IW-1:0]          rd_idx;
   logic [CW-1:0]          rd_rgb, bd_rgb;
   logic                   wr_en;
   logic signed [10:0]     wr_x0;
   lb_ent_t [TILE_PIX-1:0] wr_ent;

   bg_regfile #(.CW(CW), .NPAL(NPAL)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .scroll_x(scroll_x), .scroll_y(scroll_y), .mask_en(mask_en),
      .rd_idx(rd_idx), .rd_rgb(rd_rgb), .bd_rgb(bd_rgb)
   );

   bg_fetch #(.AW(AW), .MAP_BASE(MAP_BASE), .TILE_BASE(TILE_BASE), .MAP_ROWS(MAP_ROWS)) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .line_start(line_start), .line_num(line_num),
      .scroll_x(scroll_x), .scroll_y(scroll_y),
      .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .wr_en(wr_en), .wr_x0(wr_x0), .wr_ent(wr_ent)
   );

   bg_lineout #(.CW(CW), .IW(IW)) u_out (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_x0(wr_x0), .wr_ent(wr_ent),
      .pix_req(pix_req), .pix_x(pix_x), .mask_en(mask_en),
      .rd_idx(rd_idx), .rd_rgb(rd_rgb), .bd_rgb(bd_rgb),
      .pix_valid(pix_valid), .pix_rgb(pix_rgb), .pix_prio(pix_prio), .pix_transp(pix_transp)
   );
endmodule

// File: tb/bg_scanline_renderer_tb.sv
module bg_scanline_renderer_tb;
   localparam int MAP_BASE = 'h1C00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        line_start = 1'b0;
   logic [7:0]  line_num = '0;
   logic        busy, mem_rd_en;
   logic [12:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic        pix_req = 1'b0;
   logic [7:0]  pix_x = '0;
   logic        pix_valid, pix_prio, pix_transp;
   logic [5:0]  pix_rgb;

   always #5 clk = ~clk;

   bg_scanline_renderer u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .line_start(line_start), .line_num(line_num),
      .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .pix_req(pix_req), .pix_x(pix_x),
      .pix_valid(pix_valid), .pix_rgb(pix_rgb), .pix_prio(pix_prio), .pix_transp(pix_transp)
   );

   int checks = 0;
   int errors = 0;
   bit fin = 1'b0;
   int seed = 0;

   int m_scx = 0, m_scy = 0, m_mask = 0, m_bd = 0, m_cidx = 0;
   int m_cram [32];
   int l_scx = 0, l_scy = 0, l_line = 0;

   // Video memory contents are a pure function of address and seed; map
   // words carry random values in bits 15:13 as well (R12).
   function automatic int vram_word(input int a);
      int h;
      h = (a * 40503 + seed * 977) ^ (a >>> 5) ^ (seed << 7);
      h = h ^ (h >>> 9) ^ (h << 3);
      return h & 'hFFFF;
   endfunction

   always @(posedge clk) if (mem_rd_en) mem_rdata <= 16'(vram_word(int'(mem_addr)));

   function automatic void ref_pixel(input int x, output int rgb, output bit pr,
                                     output bit tr, output string rq);
      int mx, my, e, t, trw, w0, w1, b, ci, pal;
      if (m_mask != 0 && x < 8) begin
         rgb = m_cram[16 + m_bd]; pr = 1'b1; tr = 1'b0; rq = "R11";
         return;
      end
      mx  = (x + l_scx) % 256;
      my  = (l_line + l_scy) % 224;
      e   = vram_word(MAP_BASE + (my / 8) * 32 + (mx / 8));
      t   = e & 'h1FF;
      trw = my % 8;
      if (e[10]) trw = 7 - trw;
      w0  = vram_word(t * 16 + trw * 2);
      w1  = vram_word(t * 16 + trw * 2 + 1);
      b   = e[9] ? (mx % 8) : 7 - (mx % 8);
      ci  = (((w1 >> (8 + b)) & 1) << 3) | (((w1 >> b) & 1) << 2) |
            (((w0 >> (8 + b)) & 1) << 1) | ((w0 >> b) & 1);
      pal = (e >> 11) & 1;
      rgb = m_cram[pal * 16 + ci];
      tr  = (ci == 0);
      pr  = !tr && e[12];
      rq  = tr ? "R9" : (e[12] ? "R10" : ((e[9] || e[10]) ? "R6" : "R5"));
   endfunction

   // Per-clock comparison with the reference model.
   bit    c_req;
   int    c_x, e_rgb, busy_run = 0;
   bit    e_pr, e_tr;
   string e_rq;
   always @(posedge clk) begin
      if (rst_n && !fin) begin
         c_req = pix_req;
         c_x   = int'(pix_x);
         if (c_req) ref_pixel(c_x, e_rgb, e_pr, e_tr, e_rq);
         #2;
         checks++;
         if (pix_valid !== c_req) begin
            errors++;
            $display("FAIL R3 valid: got %0d expected %0d", pix_valid, c_req);
         end
         if (c_req) begin
            checks++;
            if (pix_rgb != 6'(e_rgb) || pix_prio != e_pr || pix_transp != e_tr) begin
               errors++;
               $display("FAIL %s line=%0d x=%0d: got rgb=%0d prio=%0d transp=%0d expected rgb=%0d prio=%0d transp=%0d",
                        e_rq, l_line, c_x, pix_rgb, pix_prio, pix_transp, e_rgb, e_pr, e_tr);
            end
         end
         if (mem_rd_en && !busy) begin
            errors++;
            $display("FAIL R2 read while idle: got mem_rd_en=1 expected 0");
         end
         if (busy) busy_run++;
         else if (busy_run > 0) begin
            checks++;
            if (busy_run != 132) begin
               errors++;
               $display("FAIL R2 fetch length: got %0d expected 132", busy_run);
            end
            busy_run = 0;
         end
      end
   end

   task automatic wr_reg(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
      case (a)
         0: m_scx = d & 255;
         1: m_scy = d & 255;
         2: begin m_mask = d & 1; m_bd = (d >> 4) & 15; end
         3: m_cidx = d & 31;
         4: begin m_cram[m_cidx] = d & 63; m_cidx = (m_cidx + 1) % 32; end
         default: ;
      endcase
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // One scanline: start, optional scroll write during the fetch, readout.
   task automatic run_line(input int ln, input int mid_scx);
      @(negedge clk);
      line_start = 1'b1; line_num = 8'(ln);
      l_line = ln; l_scx = m_scx; l_scy = m_scy;
      @(negedge clk);
      line_start = 1'b0;
      checks++;
      if (busy !== 1'b1) begin
         errors++;
         $display("FAIL R2 busy after start: got %0d expected 1", busy);
      end
      if (mid_scx >= 0) wr_reg(0, mid_scx);
      while (busy) @(negedge clk);
      for (int x = 0; x < 256; x++) begin
         pix_req = 1'b1; pix_x = 8'(x);
         @(negedge clk);
      end
      pix_req = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) m_cram[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      checks++;
      if (busy !== 1'b0 || mem_rd_en !== 1'b0 || pix_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset outputs: got busy=%0d rd=%0d valid=%0d expected 0 0 0",
                  busy, mem_rd_en, pix_valid);
      end
      // R1: zero scroll and zero colour RAM after reset; R4 R5 R6 layouts
      seed = 1;
      run_line(0, -1);
      // R8: fill colour RAM, then one extra write wraps to entry 0
      wr_reg(3, 0);
      for (int i = 0; i < 32; i++) wr_reg(4, (i * 7 + 3) & 63);
      wr_reg(4, 42);
      seed = 2;
      wr_reg(0, 3); wr_reg(1, 17);
      run_line(5, -1);
      // R7: vertical wrap at 224 and horizontal wrap at 32 columns
      wr_reg(0, 250); wr_reg(1, 100);
      run_line(191, -1);
      seed = 3;
      wr_reg(1, 240);
      run_line(60, -1);
      // R11: left column masked to backdrop entry 16+5
      wr_reg(2, 'h51);
      run_line(120, -1);
      // R8: partial rewrite from index 20, mask off again
      wr_reg(3, 20); wr_reg(4, 9); wr_reg(4, 60);
      wr_reg(2, 'h30);
      seed = 4;
      run_line(33, -1);
      // R3: a scroll write during the fetch does not affect the current line
      wr_reg(0, 77);
      run_line(150, 13);
      run_line(151, -1);
      fin = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         fin = 1'b1;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule